// File: doc/BRIEF.md
# Bit-Serial Control and Status Port

This block lets a host configure a device through a single data bit. A chain of 59 stages holds outgoing configuration in its lower 47 stages and a 12-bit status snapshot in its upper 12 stages. Each chip-select pulse carries one command, chosen by the address line and the read/write line: push one bit into the chain, take one bit out of the top of the chain, copy the lower 47 stages into the control register, or let the status stages follow the live status inputs.

All host pins are brought into the pixel-clock domain through a two-flop synchronizer. Chip-select edges are detected there, so every register changes on a pixel-clock edge. The command is taken from the falling edge of chip select. The data bit is taken from the rising edge. A committed control word therefore appears a fixed number of pixel-clock edges after chip select rises. The data pin is modelled as a separate output value and an output-enable. The enable is high only while a shift-out command holds chip select low.

A host writes a full 47-bit word, top bit first, and then commits it. To read, it first enables status refresh and then clocks bits out starting with stage 58. Reading rotates the chain, so after 59 shift-out pulses the chain is back in its starting order.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset the control output is all zeros, every chain stage is zero (so the data output is 0), and the output-enable is low.
- R2: Command address=0, rd=0 (shift-in) moves every stage up by one at chip-select rise and loads the data bit into stage 0; stage 58 is discarded.
- R3: Command address=0, rd=1 (shift-out) presents stage 58 on the data output; at chip-select rise the chain rotates up by one, stage 58 moving into stage 0.
- R4: Command address=1, rd=0 (commit) copies stages 0..46 into the control output, stage i to bit i; the control output changes on no other command.
- R5: Command address=1, rd=1 (status refresh) makes stage 47+i follow stat_in[i] on every clock, starting at chip-select rise. The falling edge of the next address=0 command freezes the status stages.
- R6: The output-enable rises only for a shift-out command while chip select is low, and it drops at the chip-select rise of that pulse.
- R7: The data bit stored by a shift-in is the value present at chip-select rise, not the value present at the fall.
- R8: The address and rd values present at chip-select fall decide the command; changing them while chip select is low has no effect.
- R9: With inputs changing between clock edges, a commit appears on the control output after the third rising pixel-clock edge that follows chip-select rise, and not before.
- R10: 59 consecutive shift-out pulses return the chain to its prior contents, so a second full read with no refresh between repeats the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| host_sel_n | input | 1 | Chip select, active low, asynchronous to clk |
| host_rd | input | 1 | Read (1) or write (0), taken at chip-select fall |
| host_addr | input | 1 | Command address bit, taken at chip-select fall |
| host_dat_in | input | 1 | Serial data from host, taken at chip-select rise |
| host_dat_out | output | 1 | Serial data to host (top chain stage) |
| host_dat_oe | output | 1 | Drive enable for the data pin; pin is released when low |
| stat_in | input | STAT_W | Live status inputs |
| ctrl_out | output | CTRL_W | Committed control word |

## Verification
The bench builds the block with its default widths: 47 control stages and 12 status stages. With these values it can run a complete 59-pulse rotation and compare two successive full reads, and it can write a full control word top bit first. It also rotates the chain partway and commits the result, which shows how rotation moves control bits into status positions and back. Pulses that change the data, address or rd lines while chip select is low cover the capture rules. A commit sampled edge by edge covers the synchronizer latency.

// File: rtl/scp_pkg.sv
package scp_pkg;
    // Command code is {address, rd}
    typedef enum logic [1:0] {
        CMD_SHIFT_IN  = 2'b00,
        CMD_SHIFT_OUT = 2'b01,
        CMD_COMMIT    = 2'b10,
        CMD_STAT_RUN  = 2'b11
    } cmd_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scp_cmd_decode.sv
module scp_cmd_decode
    import scp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_s,
    input  logic rd_s,
    input  logic addr_s,
    output logic fall_p,
    output logic rise_p,
    output cmd_e cmd_now,
    output cmd_e cmd_q,
    output logic drive_q
);
    typedef struct packed {
        logic sel_prev;
        cmd_e cmd;
        logic drive;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        cmd_now       = cmd_e'({addr_s, rd_s});
        fall_p        = st_q.sel_prev & ~sel_n_s;
        rise_p        = ~st_q.sel_prev & sel_n_s;
        st_d.sel_prev = sel_n_s;
        if (fall_p) begin
            st_d.cmd   = cmd_now;
            st_d.drive = (cmd_now == CMD_SHIFT_OUT);
        end
        if (rise_p) begin
            st_d.drive = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel_prev: 1'b1, cmd: CMD_SHIFT_IN, drive: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q   = st_q.cmd;
    assign drive_q = st_q.drive;
endmodule

// File: rtl/scp_shift_core.sv
module scp_shift_core
    import scp_pkg::*;
#(
    parameter int CTRL_W = 47,
    parameter int STAT_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fall_p,
    input  logic                     rise_p,
    input  cmd_e                     cmd_now,
    input  cmd_e                     cmd_q,
    input  logic                     din,
    input  logic [STAT_W-1:0]        stat_in,
    output logic [CTRL_W+STAT_W-1:0] sr,
    output logic                     refresh,
    output logic [CTRL_W-1:0]        ctrl
);
    localparam int TOT = CTRL_W + STAT_W;

    typedef struct packed {
        logic [TOT-1:0]    sr;
        logic              refresh;
        logic [CTRL_W-1:0] ctrl;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // live status follows inputs while refresh mode is on
        if (st_q.refresh) begin
            st_d.sr[TOT-1:CTRL_W] = stat_in;
        end
        // any address-low command freezes the status snapshot
        if (fall_p && (cmd_now == CMD_SHIFT_IN || cmd_now == CMD_SHIFT_OUT)) begin
            st_d.refresh = 1'b0;
        end
        if (rise_p) begin
            unique case (cmd_q)
                CMD_SHIFT_IN:  st_d.sr      = {st_q.sr[TOT-2:0], din};
                CMD_SHIFT_OUT: st_d.sr      = {st_q.sr[TOT-2:0], st_q.sr[TOT-1]};
                CMD_COMMIT:    st_d.ctrl    = st_q.sr[CTRL_W-1:0];
                CMD_STAT_RUN:  st_d.refresh = 1'b1;
                default:       st_d.refresh = st_q.refresh;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr      = st_q.sr;
    assign refresh = st_q.refresh;
    assign ctrl    = st_q.ctrl;
endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
    import scp_pkg::*;
#(
    parameter int CTRL_W      = 47,
    parameter int STAT_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_rd,
    input  logic              host_addr,
    input  logic              host_dat_in,
    output logic              host_dat_out,
    output logic              host_dat_oe,
    input  logic [STAT_W-1:0] stat_in,
    output logic [CTRL_W-1:0] ctrl_out
);
    localparam int TOT = CTRL_W + STAT_W;

    logic [3:0]     pins_s;
    logic           sel_n_s, rd_s, addr_s, din_s;
    logic           fall_p, rise_p;
    cmd_e           cmd_now, cmd_q;
    logic           drive_q;
    logic [TOT-1:0] sr;
    logic           refresh;

    // bundle order {data, addr, rd, sel_n}; chip select idles high
    scp_sync #(
        .W      (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0001)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({host_dat_in, host_addr, host_rd, host_sel_n}),
        .q    (pins_s)
    );

    assign {din_s, addr_s, rd_s, sel_n_s} = pins_s;

    scp_cmd_decode i_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n_s(sel_n_s),
        .rd_s   (rd_s),
        .addr_s (addr_s),
        .fall_p (fall_p),
        .rise_p (rise_p),
        .cmd_now(cmd_now),
        .cmd_q  (cmd_q),
        .drive_q(drive_q)
    );

    scp_shift_core #(
        .CTRL_W(CTRL_W),
        .STAT_W(STAT_W)
    ) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_p (fall_p),
        .rise_p (rise_p),
        .cmd_now(cmd_now),
        .cmd_q  (cmd_q),
        .din    (din_s),
        .stat_in(stat_in),
        .sr     (sr),
        .refresh(refresh),
        .ctrl   (ctrl_out)
    );

    assign host_dat_out = sr[TOT-1];
    assign host_dat_oe  = drive_q;
endmodule

// File: rtl/scp_checker.sv
module scp_checker
    import scp_pkg::*;
#(
    parameter int CTRL_W = 47,
    parameter int STAT_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rise_p,
    input cmd_e                     cmd_q,
    input logic                     din_s,
    input logic [CTRL_W+STAT_W-1:0] sr,
    input logic                     refresh,
    input logic [CTRL_W-1:0]        ctrl,
    input logic                     oe,
    input logic [STAT_W-1:0]        stat_in
);
    localparam int TOT = CTRL_W + STAT_W;

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && cmd_q == CMD_SHIFT_IN) |=> sr == {$past(sr[TOT-2:0]), $past(din_s)});

    p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && cmd_q == CMD_SHIFT_OUT) |=> sr == {$past(sr[TOT-2:0]), $past(sr[TOT-1])});

    p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && cmd_q == CMD_COMMIT) |=> ctrl == $past(sr[CTRL_W-1:0]));

    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_p && cmd_q == CMD_COMMIT) |=> $stable(ctrl));

    p_status_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> sr[TOT-1:CTRL_W] == $past(stat_in));

    p_oe_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> cmd_q == CMD_SHIFT_OUT);

    p_oe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && rise_p) |=> !oe);
endmodule

bind serial_ctl_port scp_checker #(
    .CTRL_W(CTRL_W),
    .STAT_W(STAT_W)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_p (rise_p),
    .cmd_q  (cmd_q),
    .din_s  (din_s),
    .sr     (sr),
    .refresh(refresh),
    .ctrl   (ctrl_out),
    .oe     (host_dat_oe),
    .stat_in(stat_in)
);

// File: tb/test_serial_ctl_port.sv
`timescale 1ns/1ps
module test_serial_ctl_port;
    localparam int CW  = 47;
    localparam int SW  = 12;
    localparam int TOT = CW + SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel_n = 1'b1;
    logic          host_rd = 1'b0;
    logic          host_addr = 1'b0;
    logic          host_dat_in = 1'b0;
    logic          host_dat_out;
    logic          host_dat_oe;
    logic [SW-1:0] stat_in = '0;
    logic [CW-1:0] ctrl_out;

    always #4 clk = ~clk;

    serial_ctl_port i_serial_ctl_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_sel_n  (host_sel_n),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_dat_in (host_dat_in),
        .host_dat_out(host_dat_out),
        .host_dat_oe (host_dat_oe),
        .stat_in     (stat_in),
        .ctrl_out    (ctrl_out)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model built from the requirements
    logic [TOT-1:0] m_sr   = '0;
    logic [CW-1:0]  m_ctrl = '0;
    bit             m_ref  = 1'b0;

    // scoreboard
    logic  exp_q[$];
    string tag_q[$];
    logic  smp_val;
    event  smp_ev;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial forever begin
        @(smp_ev);
        if (exp_q.size() == 0) begin
            chk("R3 unexpected read", 64'(smp_val), 64'hx);
        end else begin
            automatic logic  e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, 64'(smp_val), 64'(e));
        end
    end

    task automatic pulse(logic a, logic r, logic d);
        @(negedge clk);
        host_addr = a; host_rd = r; host_dat_in = d; host_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        host_sel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic shift_in(logic d);
        if (m_ref) begin m_sr[TOT-1:CW] = stat_in; m_ref = 1'b0; end
        pulse(1'b0, 1'b0, d);
        m_sr = {m_sr[TOT-2:0], d};
    endtask

    task automatic write_word(logic [CW-1:0] w);
        for (int i = CW - 1; i >= 0; i--) shift_in(w[i]);
    endtask

    task automatic commit();
        pulse(1'b1, 1'b0, 1'b0);
        m_ctrl = m_sr[CW-1:0];
    endtask

    task automatic refresh_on();
        pulse(1'b1, 1'b1, 1'b0);
        m_ref = 1'b1;
    endtask

    task automatic read_bit(string tag);
        if (m_ref) begin m_sr[TOT-1:CW] = stat_in; m_ref = 1'b0; end
        exp_q.push_back(m_sr[TOT-1]);
        tag_q.push_back(tag);
        @(negedge clk);
        host_addr = 1'b0; host_rd = 1'b1; host_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        smp_val = host_dat_out;
        -> smp_ev;
        if (!host_dat_oe) chk("R6 oe during read", 64'(host_dat_oe), 64'h1);
        host_sel_n = 1'b1;
        repeat (4) @(negedge clk);
        m_sr = {m_sr[TOT-2:0], m_sr[TOT-1]};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 ctrl after reset", 64'(ctrl_out), 64'h0);
        chk("R1 oe after reset", 64'(host_dat_oe), 64'h0);
        chk("R1 data out after reset", 64'(host_dat_out), 64'h0);

        // R2 shift in a word; R4 no change before commit
        write_word(47'h2A5C_3C96_E1F7);
        chk("R4 ctrl before commit", 64'(ctrl_out), 64'h0);

        // R9 commit latency, edge by edge
        @(negedge clk);
        host_addr = 1'b1; host_rd = 1'b0; host_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        host_sel_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 ctrl before third edge", 64'(ctrl_out), 64'h0);
        @(negedge clk);
        m_ctrl = m_sr[CW-1:0];
        chk("R9 R4 ctrl after third edge", 64'(ctrl_out), 64'(m_ctrl));
        repeat (2) @(negedge clk);

        // R5 refresh follows live status; R3 read order; R10 rotation
        stat_in = 12'hA53;
        refresh_on();
        stat_in = 12'h6C9;
        repeat (3) @(negedge clk);
        for (int i = 0; i < TOT; i++) read_bit("R5 R3 first full read");
        chk("R6 oe released", 64'(host_dat_oe), 64'h0);
        stat_in = 12'hF0F;
        for (int i = 0; i < TOT; i++) read_bit("R10 second full read");

        // R3 partial read then commit exposes the rotation
        stat_in = 12'h3E4;
        refresh_on();
        for (int i = 0; i < 5; i++) read_bit("R3 partial read");
        commit();
        chk("R3 rotated commit", 64'(ctrl_out), 64'(m_ctrl));

        // R7 data taken at rise
        if (m_ref) begin m_sr[TOT-1:CW] = stat_in; m_ref = 1'b0; end
        @(negedge clk);
        host_addr = 1'b0; host_rd = 1'b0; host_dat_in = 1'b0; host_sel_n = 1'b0;
        repeat (2) @(negedge clk);
        host_dat_in = 1'b1;
        repeat (2) @(negedge clk);
        host_sel_n = 1'b1;
        repeat (4) @(negedge clk);
        m_sr = {m_sr[TOT-2:0], 1'b1};

        // R8 command fixed at fall
        @(negedge clk);
        host_addr = 1'b0; host_rd = 1'b0; host_dat_in = 1'b0; host_sel_n = 1'b0;
        repeat (2) @(negedge clk);
        host_addr = 1'b1; host_rd = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 oe stays low", 64'(host_dat_oe), 64'h0);
        host_sel_n = 1'b1;
        repeat (4) @(negedge clk);
        m_sr = {m_sr[TOT-2:0], 1'b0};
        chk("R8 ctrl unchanged", 64'(ctrl_out), 64'(m_ctrl));
        commit();
        chk("R7 R8 commit after edge cases", 64'(ctrl_out), 64'(m_ctrl));

        // R2 R4 second word, then repeated commit keeps value
        write_word(47'h1357_9BDF_0246);
        commit();
        chk("R2 R4 second word", 64'(ctrl_out), 64'h1357_9BDF_0246);
        commit();
        chk("R4 repeated commit", 64'(ctrl_out), 64'h1357_9BDF_0246);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", 64'(exp_q.size()), 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule